// File: doc/BRIEF.md
# External Interrupt Sense and Vector Unit

This unit conditions eight external interrupt lines for a processor. Each line can be set up either as an active-low level source or as a falling-edge source. A falling edge sets a per-line latch that holds the request until software clears it. A low level is pending only while the line stays low. The unit combines each line's pending state with a per-line enable mask. It drives one interrupt request to the processor and reports a vector number for the winning source.

Software reaches four 32-bit registers through a simple bus with a word address, a write strobe and a read strobe. Register bits are numbered from the most significant end for the mask and pending words, so source n sits at word bit 31−n. The sense word uses bit 15−n for line n, so line 0 is at bit 15 and line 7 is at bit 8. The vector numbers are sparse: line 0 reports 48 and lines 1 to 7 report 17 to 23. Each input passes through a two-flop synchronizer before it is used.

Top module: `ext_irq_sense_vec`

## Requirements
- R1: After reset the sense, mask and pending words all read 0, the vector reads 0 and `irq_req_o` is low.
- R2: The sense word is at address 0. Line n is configured by bit 15−n, where 1 selects falling-edge mode and 0 selects low-level mode. All other bits are ignored on write and read as 0.
- R3: The mask word is at address 1. Line n is enabled by bit 31−n being 1. A disabled source still shows in the pending word, but it neither raises `irq_req_o` nor appears in the vector. All other bits read as 0.
- R4: In low-level mode a line is pending while its synchronized input is low. It stops being pending when the input returns high. A clearing write has no lasting effect while the line stays low.
- R5: In edge mode a high-to-low transition sets the line's latch. The latch stays set after the input returns high. A rising transition, or a line that stays low after a clear, does not set it.
- R6: The pending word is at address 2 and shows line n at bit 31−n. Writing a 1 at bit 31−n clears line n's edge latch, and bits written 0 leave their latches unchanged.
- R7: When a falling edge and a clearing write for the same line fall in the same cycle, the latch stays set.
- R8: The vector word is at address 3 and carries the source number in bits 6:0, with the upper bits 0. Line 0 reports 48, line k (1..7) reports 16+k, and 0 means no enabled source is pending.
- R9: When several enabled sources are pending, the lowest line index wins the vector.
- R10: `irq_req_o` is high exactly when at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | 8 | External interrupt lines, asynchronous |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when the read strobe is low |
| irq_req_o | output | 1 | Interrupt request to the processor |

## Verification
Single low levels are driven on single lines with the mask open and with it closed. These patterns separate the raw pending state from the gated request and vector. Edge tests drive a falling transition, then a release, then a steady low after a clear, then a rising transition; together they separate a latched edge from level following. A clearing write is placed on the same cycle as a falling edge to show that the set wins. Several lines are made pending at once, and lines are then masked away one by one, so that the fixed ranking and the sparse vector numbers are both visible.

// File: rtl/ext_irq_sense_vec.sv
module ext_irq_sense_vec #(
  parameter int NLINES     = 8,
  parameter int AW         = 2,
  parameter int DW         = 32,
  parameter int VW         = 7,
  parameter int SENSE_TOP  = 15,
  parameter int LINE0_CODE = 48,
  parameter int LINEK_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_n_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_req_o
);

  localparam logic [AW-1:0] A_SENSE = AW'(0);
  localparam logic [AW-1:0] A_MASK  = AW'(1);
  localparam logic [AW-1:0] A_PEND  = AW'(2);
  localparam logic [AW-1:0] A_VEC   = AW'(3);

  logic [NLINES-1:0] s1_q, s2_q, prev_q;
  logic [NLINES-1:0] latch_q, sense_q, mask_q;
  logic [NLINES-1:0] clr, fall, pend, active;
  logic [VW-1:0]     vec_w;
  logic [DW-1:0]     rd_word;

  wire wr_sense = bus_wr && (bus_addr == A_SENSE);
  wire wr_mask  = bus_wr && (bus_addr == A_MASK);
  wire wr_pend  = bus_wr && (bus_addr == A_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= irq_n_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall   = prev_q & ~s2_q;
  assign pend   = (sense_q & latch_q) | (~sense_q & ~s2_q);
  assign active = pend & mask_q;

  always_comb begin
    for (int n = 0; n < NLINES; n++) clr[n] = wr_pend && bus_wdata[DW-1-n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      sense_q <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~clr) | (fall & sense_q);
      for (int n = 0; n < NLINES; n++) begin
        if (wr_sense) sense_q[n] <= bus_wdata[SENSE_TOP-n];
        if (wr_mask)  mask_q[n]  <= bus_wdata[DW-1-n];
      end
    end
  end

  always_comb begin
    vec_w = '0;
    for (int n = NLINES-1; n >= 0; n--) begin
      if (active[n]) vec_w = (n == 0) ? VW'(LINE0_CODE) : VW'(LINEK_BASE + n);
    end
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      A_SENSE: for (int n = 0; n < NLINES; n++) rd_word[SENSE_TOP-n] = sense_q[n];
      A_MASK:  for (int n = 0; n < NLINES; n++) rd_word[DW-1-n] = mask_q[n];
      A_PEND:  for (int n = 0; n < NLINES; n++) rd_word[DW-1-n] = pend[n];
      default: rd_word[VW-1:0] = vec_w;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_word : '0;
  assign irq_req_o = |active;

endmodule

// File: rtl/ext_irq_sense_vec_chk.sv
module ext_irq_sense_vec_chk #(
  parameter int NLINES = 8,
  parameter int AW     = 2,
  parameter int DW     = 32,
  parameter int VW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] latch_q,
  input logic [NLINES-1:0] sense_q,
  input logic [NLINES-1:0] mask_q,
  input logic [VW-1:0]     vec_w,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq_req_o
);

  logic [NLINES-1:0] clr_seen;
  always_comb begin
    for (int n = 0; n < NLINES; n++)
      clr_seen[n] = bus_wr && (bus_addr == AW'(2)) && bus_wdata[DW-1-n];
  end

  AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (mask_q != '0)); // R3

  AST_VEC_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == (vec_w != '0)); // R10

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q) & ~$past(clr_seen) & ~latch_q) == '0)); // R6

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(latch_q) & latch_q & ~$past(sense_q)) == '0)); // R2

endmodule

bind ext_irq_sense_vec ext_irq_sense_vec_chk #(
  .NLINES(NLINES), .AW(AW), .DW(DW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .sense_q(sense_q),
  .mask_q(mask_q), .vec_w(vec_w), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_req_o(irq_req_o)
);

// File: tb/ext_irq_sense_vec_tb.sv
module ext_irq_sense_vec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n = 8'hFF;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense_vec u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_req_o(irq_req)
  );

  function automatic logic [31:0] pos(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cy(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic expect_reg(string tag, logic [1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 sense", 2'd0, 32'h0);
    expect_reg("R1 mask", 2'd1, 32'h0);
    expect_reg("R1 pend", 2'd2, 32'h0);
    expect_reg("R1 vec", 2'd3, 32'h0);
    check("R1 irq", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_regs;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    expect_reg("R2 sense bits", 2'd0, 32'h0000_FF00);
    wr_reg(2'd0, 32'h0000_8000);
    expect_reg("R2 line0 at bit15", 2'd0, 32'h0000_8000);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    expect_reg("R3 mask bits", 2'd1, 32'hFF00_0000);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h0);
  endtask

  task automatic t_level;
    wr_reg(2'd1, 32'hFF00_0000);
    irq_n[3] = 1'b0;
    wait_cy(4);
    expect_reg("R4 level pend", 2'd2, pos(3));
    expect_reg("R8 vec line3", 2'd3, 32'd19);
    check("R10 irq on", {31'b0, irq_req}, 32'h1);
    wr_reg(2'd2, pos(3));
    wait_cy(2);
    expect_reg("R4 clear while low", 2'd2, pos(3));
    irq_n[3] = 1'b1;
    wait_cy(4);
    expect_reg("R4 released", 2'd2, 32'h0);
    expect_reg("R8 vec none", 2'd3, 32'h0);
    check("R10 irq off", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_mask;
    wr_reg(2'd1, 32'h0);
    irq_n[5] = 1'b0;
    wait_cy(4);
    expect_reg("R3 masked still pending", 2'd2, pos(5));
    expect_reg("R3 masked vec", 2'd3, 32'h0);
    check("R3 masked irq", {31'b0, irq_req}, 32'h0);
    irq_n[5] = 1'b1;
    wait_cy(4);
  endtask

  task automatic t_edge;
    wr_reg(2'd1, 32'hFF00_0000);
    wr_reg(2'd0, 32'h0000_8000);
    irq_n[0] = 1'b0;
    wait_cy(4);
    expect_reg("R8 vec line0", 2'd3, 32'd48);
    irq_n[0] = 1'b1;
    wait_cy(4);
    expect_reg("R5 latched after release", 2'd2, pos(0));
    wr_reg(2'd2, ~pos(0));
    expect_reg("R6 zero bit keeps", 2'd2, pos(0));
    wr_reg(2'd2, pos(0));
    expect_reg("R6 w1c clears", 2'd2, 32'h0);
    irq_n[0] = 1'b0;
    wait_cy(4);
    wr_reg(2'd2, pos(0));
    wait_cy(3);
    expect_reg("R5 steady low no set", 2'd2, 32'h0);
    irq_n[0] = 1'b1;
    wait_cy(4);
    expect_reg("R5 rising no set", 2'd2, 32'h0);
    check("R10 idle", {31'b0, irq_req}, 32'h0);
    wr_reg(2'd0, 32'h0);
  endtask

  task automatic t_prio;
    irq_n[2] = 1'b0; irq_n[6] = 1'b0; irq_n[7] = 1'b0;
    wait_cy(4);
    expect_reg("R9 lowest of 2,6,7", 2'd3, 32'd18);
    wr_reg(2'd1, 32'hFF00_0000 & ~pos(2));
    expect_reg("R9 after masking 2", 2'd3, 32'd22);
    wr_reg(2'd1, pos(7));
    expect_reg("R8 vec line7", 2'd3, 32'd23);
    irq_n[2] = 1'b1; irq_n[6] = 1'b1; irq_n[7] = 1'b1;
    wr_reg(2'd1, 32'hFF00_0000);
    wr_reg(2'd0, 32'h0000_8000);
    irq_n[1] = 1'b0;
    irq_n[0] = 1'b0;
    wait_cy(4);
    expect_reg("R9 line0 beats line1", 2'd3, 32'd48);
    wr_reg(2'd2, pos(0));
    expect_reg("R8 vec line1", 2'd3, 32'd17);
    irq_n[0] = 1'b1; irq_n[1] = 1'b1;
    wr_reg(2'd0, 32'h0);
    wait_cy(4);
  endtask

  task automatic t_collide;
    wr_reg(2'd0, 32'h0000_0800);
    irq_n[4] = 1'b0;
    wait_cy(4);
    irq_n[4] = 1'b1;
    wait_cy(4);
    expect_reg("R5 line4 latched", 2'd2, pos(4));
    @(negedge clk);
    irq_n[4] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = 2'd2; wdata = pos(4); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    wait_cy(2);
    expect_reg("R7 edge beats clear", 2'd2, pos(4));
    irq_n[4] = 1'b1;
    wait_cy(4);
  endtask

  initial begin
    wait_cy(3);
    rst_n = 1'b1;
    wait_cy(2);
    t_reset();
    t_regs();
    t_level();
    t_mask();
    t_edge();
    t_prio();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule